// File: doc/BRIEF.md
# PWM Period Sync Pulse Unit

This block links a PWM counter's period timing to the outside world in one of two modes. In internal mode it turns the counter's period-start strobe into a sync pin pulse whose width is set by software. When double update is selected, the period-midpoint strobe makes a pulse as well. In external mode the pin becomes an input. A pulse arriving on it passes through a two-flop synchronizer and a rising-edge detector, and the result is a one-cycle restart request to the PWM counter.

The pin direction follows the mode bit, so a pad or another block can use `sync_oe` to decide who drives the line. The counter and the strobes it makes belong to other logic. This unit only shapes pulses and detects edges.

Top module: `pwm_sync_unit`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `sync_out` and `cnt_restart` are 0.
- R2: In internal mode (`ext_mode`=0), a `prd_start` high at a clock edge makes `sync_out` high from that edge for exactly `width`+1 cycles.
- R3: A `prd_mid` high at an edge starts the same pulse only when `dbl_upd`=1. With `dbl_upd`=0 it is ignored and `sync_out` stays low.
- R4: A `width` value of 0 gives a `sync_out` pulse exactly one clock cycle wide.
- R5: An event that arrives while a pulse is active reloads the width count from the current `width`. The pulse then lasts `width`+1 cycles from that later edge.
- R6: `sync_oe` equals the inverse of `ext_mode`. In external mode, `sync_out` is 0 from the first edge that samples `ext_mode`=1, and period strobes are ignored. Changing to external mode cuts off any pulse in progress.
- R7: In external mode, a rising edge on `sync_in` that is held for at least three clock periods raises `cnt_restart` for exactly one cycle. The pulse comes after the second clock edge that samples `sync_in` high.
- R8: `cnt_restart` is never high in internal mode, whatever `sync_in` does.
- R9: A `sync_in` level held high produces only one restart, and a falling edge on `sync_in` produces none.
- R10: The width count is loaded only when an event occurs. A change to `width` during a pulse does not alter that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects external sync input, 0 selects internal pulse output |
| dbl_upd | input | 1 | 1 lets the midpoint strobe make a pulse |
| width | input | WIDTH_W | Pulse width minus one, in clock cycles |
| prd_start | input | 1 | Period-start strobe from the PWM counter |
| prd_mid | input | 1 | Period-midpoint strobe from the PWM counter |
| sync_in | input | 1 | Asynchronous external sync pin input |
| sync_out | output | 1 | Internal sync pulse to the pin |
| sync_oe | output | 1 | Pin output enable, high in internal mode |
| cnt_restart | output | 1 | One-cycle restart request to the PWM counter |

## Verification
The properties assume that `sync_in` is stable around each sampling edge. Under that assumption, the value seen two and three edges back is the value the synchronizer holds. They also assume that `ext_mode` and the strobes are ordinary synchronous inputs. The bench changes every input, `sync_in` included, only on the falling clock edge, so the synchronizer never sees a transition at its sampling edge. External pulses in the bench last three cycles or longer, which keeps them within the minimum-width rule.

// File: rtl/pwm_sync_unit.sv
module pwm_sync_unit #(
  parameter int WIDTH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_mode,
  input  logic               dbl_upd,
  input  logic [WIDTH_W-1:0] width,
  input  logic               prd_start,
  input  logic               prd_mid,
  input  logic               sync_in,
  output logic               sync_out,
  output logic               sync_oe,
  output logic               cnt_restart
);

  logic [WIDTH_W-1:0] cnt;
  logic               active;
  logic [2:0]         sh;
  logic               evt;

  assign evt = prd_start | (dbl_upd & prd_mid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (ext_mode) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (evt) begin
      active <= 1'b1;
      cnt    <= width;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], sync_in};
  end

  assign sync_out    = active;
  assign sync_oe     = ~ext_mode;
  assign cnt_restart = ext_mode & sh[1] & ~sh[2];

endmodule

module pwm_sync_unit_chk #(
  parameter int WIDTH_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ext_mode,
  input logic               dbl_upd,
  input logic [WIDTH_W-1:0] width,
  input logic               prd_start,
  input logic               prd_mid,
  input logic               sync_in,
  input logic               sync_out,
  input logic               cnt_restart
);

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && prd_start) |=> sync_out);

  // R3
  mid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && dbl_upd && prd_mid) |=> sync_out);

  // R4
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && prd_start && width == '0) ##1 !(prd_start || prd_mid) |=> !sync_out);

  // R6
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ext_mode) && ext_mode) |-> !sync_out);

  // R7
  restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_restart |-> ($past(sync_in, 2) && !$past(sync_in, 3)));

  // R9
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_restart |=> !cnt_restart);

endmodule

bind pwm_sync_unit pwm_sync_unit_chk #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .dbl_upd(dbl_upd),
  .width(width), .prd_start(prd_start), .prd_mid(prd_mid),
  .sync_in(sync_in), .sync_out(sync_out), .cnt_restart(cnt_restart)
);

// File: tb/sim_pwm_sync_unit.sv
module sim_pwm_sync_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_mode = 1'b0, dbl_upd = 1'b0, prd_start = 1'b0, prd_mid = 1'b0, sync_in = 1'b0;
  logic [3:0] width = 4'd0;
  logic       sync_out, sync_oe, cnt_restart;
  int tests = 0, failed = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_sync_unit #(.WIDTH_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .dbl_upd(dbl_upd),
    .width(width), .prd_start(prd_start), .prd_mid(prd_mid), .sync_in(sync_in),
    .sync_out(sync_out), .sync_oe(sync_oe), .cnt_restart(cnt_restart)
  );

  // {ext, dbl, width[3:0], start, mid, sync_in, exp_out, exp_restart}
  localparam logic [10:0] VEC [0:17] = '{
    {1'b0,1'b0,4'd2,1'b1,1'b0,1'b0,1'b1,1'b0},  // R2
    {1'b0,1'b0,4'd2,1'b0,1'b0,1'b0,1'b1,1'b0},
    {1'b0,1'b0,4'd2,1'b0,1'b0,1'b0,1'b1,1'b0},
    {1'b0,1'b0,4'd2,1'b0,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b0,4'd2,1'b0,1'b1,1'b0,1'b0,1'b0},  // R3 ignored
    {1'b0,1'b1,4'd0,1'b0,1'b1,1'b0,1'b1,1'b0},  // R3 R4
    {1'b0,1'b1,4'd0,1'b0,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b0,4'd3,1'b1,1'b0,1'b0,1'b1,1'b0},  // R5
    {1'b0,1'b0,4'd3,1'b0,1'b0,1'b0,1'b1,1'b0},
    {1'b0,1'b0,4'd1,1'b1,1'b0,1'b0,1'b1,1'b0},
    {1'b0,1'b0,4'd1,1'b0,1'b0,1'b0,1'b1,1'b0},
    {1'b0,1'b0,4'd1,1'b0,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b0,4'd2,1'b1,1'b0,1'b0,1'b0,1'b0},  // R6
    {1'b1,1'b0,4'd2,1'b0,1'b0,1'b1,1'b0,1'b0},  // R7
    {1'b1,1'b0,4'd2,1'b0,1'b0,1'b1,1'b0,1'b1},
    {1'b1,1'b0,4'd2,1'b0,1'b0,1'b1,1'b0,1'b0},
    {1'b1,1'b0,4'd2,1'b0,1'b0,1'b0,1'b0,1'b0},  // R9
    {1'b1,1'b0,4'd2,1'b0,1'b0,1'b0,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    int cnt;
    step(); step();
    chk("R1 reset sync_out", sync_out, 0);
    chk("R1 reset restart", cnt_restart, 0);
    rst_n = 1'b1;
    step();
    chk("R1 after reset sync_out", sync_out, 0);
    chk("R1 after reset restart", cnt_restart, 0);

    for (int i = 0; i < 18; i++) begin
      {ext_mode, dbl_upd, width, prd_start, prd_mid, sync_in} = VEC[i][10:2];
      step();
      chk($sformatf("R2-table vec %0d sync_out", i), sync_out, VEC[i][1]);
      chk($sformatf("R7 table vec %0d restart", i), cnt_restart, VEC[i][0]);
      chk($sformatf("R6 table vec %0d sync_oe", i), sync_oe, !VEC[i][10]);
    end

    // R2: maximum width gives 16 cycles
    ext_mode = 0; dbl_upd = 0; prd_mid = 0; sync_in = 0;
    width = 4'd15; prd_start = 1; step(); prd_start = 0;
    cnt = (sync_out === 1'b1) ? 1 : 0;
    for (int k = 0; k < 20; k++) begin step(); if (sync_out === 1'b1) cnt++; end
    chk("R2 max width cycles", cnt, 16);

    // R10: width change during a pulse
    width = 4'd1; prd_start = 1; step(); prd_start = 0; width = 4'd7;
    cnt = (sync_out === 1'b1) ? 1 : 0;
    for (int k = 0; k < 12; k++) begin step(); if (sync_out === 1'b1) cnt++; end
    chk("R10 width change ignored", cnt, 2);

    // R6: mode change cuts pulse
    width = 4'd5; prd_start = 1; step(); prd_start = 0;
    chk("R6 pulse started", sync_out, 1);
    ext_mode = 1; step();
    chk("R6 pulse cut", sync_out, 0);
    chk("R6 oe low", sync_oe, 0);

    // R9: long held input yields one restart
    cnt = 0;
    sync_in = 1;
    for (int k = 0; k < 10; k++) begin step(); if (cnt_restart === 1'b1) cnt++; end
    sync_in = 0;
    for (int k = 0; k < 6; k++) begin step(); if (cnt_restart === 1'b1) cnt++; end
    chk("R9 single restart", cnt, 1);

    // R8: internal mode never restarts
    ext_mode = 0; cnt = 0;
    for (int k = 0; k < 12; k++) begin sync_in = k[2]; step(); if (cnt_restart === 1'b1) cnt++; end
    chk("R8 no restart internal", cnt, 0);
    chk("R6 oe high", sync_oe, 1);

    // R7: three-cycle pulse recognised, timing
    ext_mode = 1; sync_in = 0; step(); step(); step();
    sync_in = 1; step();
    chk("R7 first edge", cnt_restart, 0);
    step();
    chk("R7 second edge", cnt_restart, 1);
    step(); sync_in = 0;
    chk("R7 after", cnt_restart, 0);
    step(); step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule